// File: doc/BRIEF.md
# Snapshot Register Window for a Calendar Clock

This block places a sixteen-byte register window between a simple synchronous host bus and a free-running calendar counter. The counter advances once per one-second strobe and tracks seconds, minutes, hours, weekday, day of month, month, year and century in BCD, with month lengths and leap years. The host never reads the counter directly. It reads a visible copy that follows the counter on every strobe, so a multi-byte read cannot catch a value in the middle of a carry.

A flags register gives the host two controls. The hold bit freezes the visible copy while the counter keeps running, so a consistent snapshot can be read at leisure. When the hold bit is released, the copy catches up on the next strobe. The stage bit also freezes the copy and turns it into a staging area for a new base time. When the stage bit is cleared, all eight fields move into the counter in one cycle and counting resumes from them.

Top module: `clk_shadow_regs`

## Requirements
- R1: Offset 0x0 is the flags register. Offsets 0x8 to 0xF hold, in this order, seconds, minutes, hours, weekday, date, month, year and century, all in BCD. Offsets 0x1 to 0x7 read 0x00 and writes to them are ignored.
- R2: A read (bus_cs=1, bus_we=0) at offset A in one cycle presents the value of A on bus_rdata from the next clock edge on. bus_rdata keeps that value until the next read.
- R3: Each cycle with tick_1hz=1 advances the counter by one second. Seconds and minutes roll from 59 to 00, hours from 23 to 00, weekday from 7 to 1, date to 1 after the month's last day, month from 12 to 1, year from 99 to 00 with a carry into century, and century from 99 to 00.
- R4: February has 29 days when the year is a multiple of 4 and nonzero, or when the year is 00 and the century is a multiple of 4. Otherwise it has 28 days. April, June, September and November have 30 days and the other months have 31.
- R5: With both flag bits clear, the visible copy takes the counter's new value at every tick.
- R6: Writing flags bit 0 (hold) as 1 freezes the visible copy. The counter keeps counting ticks during the hold.
- R7: After bit 0 is cleared, the visible copy is unchanged until the next tick. It then shows the counter, including every second counted during the hold.
- R8: While flags bit 1 (stage) is 1, ticks do not change the visible copy, and writes to 0x8 to 0xF store the written byte into that field.
- R9: Writing the flags with bit 1 = 0 while it is 1 loads all eight visible fields into the counter on that edge. Later ticks count on from the loaded time.
- R10: Writes to 0x8 to 0xF while flags bit 1 is 0 are ignored, whether bit 0 is set or not.
- R11: Unused bits read as 0. The used-bit masks are: flags 0x03, seconds 0x7F, minutes 0x7F, hours 0x3F, weekday 0x07, date 0x3F, month 0x1F, year 0xFF, century 0xFF. Masked bits are discarded on write.
- R12: After reset the flags read 0x00, the time reads century 0x20, year 0x00, month 0x01, date 0x01, weekday 0x01, 00:00:00, and bus_rdata is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle strobe, once per second |
| bus_cs | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register offset within the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, one cycle latency |

## Verification
The bench targets the calendar carries: the end of a leap February in a normal year and in a year 00 of a multiple-of-four century, a year-00 February that must not be leap, a 30-day month, and a full rollover from year 99 into the next century. A wrong carry chain would show a date of 29 or 30 where 1 belongs, or leave the century unchanged. It checks that released holds refresh only on the next tick and include the seconds counted while frozen. A design that stopped the counter during the hold would come back short by those seconds, and one that refreshed at once would fail the pre-tick read. It also writes bytes to time registers while the stage bit is clear, and writes bytes with out-of-range high bits, so that a missing gate or mask shows up as a changed readback.

// File: rtl/clkshadow_pkg.sv
package clkshadow_pkg;

    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 8;
    localparam int TK_NUM   = 8;
    localparam int TK_IDX_W = $clog2(TK_NUM);
    localparam int TK_W     = TK_NUM * DATA_W;

    localparam logic [ADDR_W-1:0] FLAG_OFS = 4'h0;
    localparam logic [ADDR_W-1:0] TK_BASE  = 4'h8;
    localparam int HOLD_BIT  = 0;
    localparam int STAGE_BIT = 1;

    // sec is the least significant byte: field i sits at bits [i*8 +: 8]
    typedef struct packed {
        logic [7:0] cen;
        logic [7:0] yr;
        logic [7:0] mon;
        logic [7:0] date;
        logic [7:0] wday;
        logic [7:0] hr;
        logic [7:0] min;
        logic [7:0] sec;
    } tk_t;

    localparam tk_t TK_RESET = '{cen: 8'h20, yr: 8'h00, mon: 8'h01, date: 8'h01,
                                 wday: 8'h01, hr: 8'h00, min: 8'h00, sec: 8'h00};

    function automatic logic [7:0] fld_mask(input logic [TK_IDX_W-1:0] i);
        case (i)
            3'd0, 3'd1: return 8'h7F;
            3'd2, 3'd4: return 8'h3F;
            3'd3:       return 8'h07;
            3'd5:       return 8'h1F;
            default:    return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] rd_mask(input logic [ADDR_W-1:0] a);
        if (a == FLAG_OFS) return 8'h03;
        if (a >= TK_BASE)  return fld_mask(TK_IDX_W'(a - TK_BASE));
        return 8'h00;
    endfunction

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'h9) return {v[7:4] + 4'd1, 4'h0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic int bcd2bin(input logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic logic is_leap(input logic [7:0] yr, input logic [7:0] cen);
        if (bcd2bin(yr) % 4 != 0) return 1'b0;
        if (yr != 8'h00)          return 1'b1;
        return (bcd2bin(cen) % 4 == 0);
    endfunction

    function automatic logic [7:0] month_len(input logic [7:0] mon, input logic leap);
        case (mon)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    // one-second step through the whole carry chain
    function automatic tk_t tk_advance(input tk_t t);
        tk_t  n;
        logic c;
        n     = t;
        c     = (t.sec == 8'h59);
        n.sec = c ? 8'h00 : bcd_inc(t.sec);
        if (c) begin
            c     = (t.min == 8'h59);
            n.min = c ? 8'h00 : bcd_inc(t.min);
        end
        if (c) begin
            c    = (t.hr == 8'h23);
            n.hr = c ? 8'h00 : bcd_inc(t.hr);
        end
        if (c) begin
            n.wday = (t.wday == 8'h07) ? 8'h01 : bcd_inc(t.wday);
            c      = (t.date == month_len(t.mon, is_leap(t.yr, t.cen)));
            n.date = c ? 8'h01 : bcd_inc(t.date);
        end
        if (c) begin
            c     = (t.mon == 8'h12);
            n.mon = c ? 8'h01 : bcd_inc(t.mon);
        end
        if (c) begin
            c    = (t.yr == 8'h99);
            n.yr = c ? 8'h00 : bcd_inc(t.yr);
        end
        if (c) begin
            n.cen = (t.cen == 8'h99) ? 8'h00 : bcd_inc(t.cen);
        end
        return n;
    endfunction

endpackage

// File: rtl/clkshadow_counter.sv
module clkshadow_counter
    import clkshadow_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic load,
    input  tk_t  load_val,
    output tk_t  cur,
    output tk_t  nxt
);

    tk_t cnt_q;

    assign nxt = tk_advance(cnt_q);
    assign cur = cnt_q;

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= TK_RESET;
        else if (load) cnt_q <= load_val;
        else if (tick) cnt_q <= nxt;
    end

endmodule

// File: rtl/clkshadow_view.sv
module clkshadow_view
    import clkshadow_pkg::*;
#(
    parameter int NUM   = TK_NUM,
    parameter int IDX_W = TK_IDX_W
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             hold,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  tk_t              fresh,
    output tk_t              view
);

    logic [NUM*8-1:0] fresh_flat;
    logic [NUM*8-1:0] view_flat;
    logic [NUM*8-1:0] rst_flat;

    assign fresh_flat = fresh;
    assign rst_flat   = TK_RESET;

    for (genvar g = 0; g < NUM; g++) begin : g_fld
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= rst_flat[g*8 +: 8];
            else if (wr_en && wr_idx == IDX_W'(g))
                q <= wr_data & fld_mask(IDX_W'(g));
            else if (tick && !hold)
                q <= fresh_flat[g*8 +: 8];
        end
        assign view_flat[g*8 +: 8] = q;
    end

    assign view = view_flat;

endmodule

// File: rtl/clk_shadow_regs.sv
module clk_shadow_regs
    import clkshadow_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic              bus_cs,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);

    logic                frz_q, stage_q;
    logic                flag_wr, in_tk, tk_wr, commit, hold;
    logic [TK_IDX_W-1:0] tk_idx;
    logic [DATA_W-1:0]   rd_val, rdata_q;
    logic [TK_W-1:0]     vis_flat;
    tk_t                 vis, cnt, cnt_nxt;

    assign in_tk   = (bus_addr >= TK_BASE);
    assign tk_idx  = TK_IDX_W'(bus_addr - TK_BASE);
    assign flag_wr = bus_cs && bus_we && (bus_addr == FLAG_OFS);
    assign tk_wr   = bus_cs && bus_we && in_tk && stage_q;
    assign commit  = flag_wr && stage_q && !bus_wdata[STAGE_BIT];
    assign hold    = frz_q || stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frz_q   <= 1'b0;
            stage_q <= 1'b0;
        end else if (flag_wr) begin
            frz_q   <= bus_wdata[HOLD_BIT];
            stage_q <= bus_wdata[STAGE_BIT];
        end
    end

    clkshadow_counter i_counter (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_1hz),
        .load     (commit),
        .load_val (vis),
        .cur      (cnt),
        .nxt      (cnt_nxt)
    );

    clkshadow_view #(.NUM(TK_NUM), .IDX_W(TK_IDX_W)) i_view (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_1hz),
        .hold    (hold),
        .wr_en   (tk_wr),
        .wr_idx  (tk_idx),
        .wr_data (bus_wdata),
        .fresh   (cnt_nxt),
        .view    (vis)
    );

    assign vis_flat = vis;

    always_comb begin
        rd_val = '0;
        if (bus_addr == FLAG_OFS) begin
            rd_val[HOLD_BIT]  = frz_q;
            rd_val[STAGE_BIT] = stage_q;
        end else if (in_tk) begin
            rd_val = vis_flat[{tk_idx, 3'b000} +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                  rdata_q <= '0;
        else if (bus_cs && !bus_we) rdata_q <= rd_val;
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/clk_shadow_chk.sv
module clk_shadow_chk
    import clkshadow_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick_1hz,
    input logic              bus_cs,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              frz_q,
    input logic              stage_q,
    input logic              tk_wr,
    input logic              commit,
    input tk_t               vis,
    input tk_t               cnt
);

    assert_rdata_masked_R11: assert property (@(posedge clk) disable iff (rst)
        $past(bus_cs && !bus_we) |-> ((bus_rdata & ~rd_mask($past(bus_addr))) == 8'h00));

    assert_rdata_holds_R2: assert property (@(posedge clk) disable iff (rst)
        !(bus_cs && !bus_we) |=> $stable(bus_rdata));

    assert_view_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        (frz_q || stage_q) && !tk_wr |=> $stable(vis));

    assert_count_in_hold_R6: assert property (@(posedge clk) disable iff (rst)
        frz_q && tick_1hz && !commit |=> (cnt != $past(cnt)));

    assert_refresh_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
        !frz_q && !stage_q && tick_1hz |=> (vis == cnt));

    assert_commit_loads_R9: assert property (@(posedge clk) disable iff (rst)
        commit |=> (cnt == $past(vis)));

    assert_ignored_write_R10: assert property (@(posedge clk) disable iff (rst)
        bus_cs && bus_we && (bus_addr >= TK_BASE) && !stage_q && !tick_1hz |=> $stable(vis));

endmodule

bind clk_shadow_regs clk_shadow_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_1hz  (tick_1hz),
    .bus_cs    (bus_cs),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .frz_q     (frz_q),
    .stage_q   (stage_q),
    .tk_wr     (tk_wr),
    .commit    (commit),
    .vis       (vis),
    .cnt       (cnt)
);

// File: tb/test_clk_shadow_regs.sv
`timescale 1ns/100ps
module test_clk_shadow_regs;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1hz = 1'b0;
    logic       bus_cs = 1'b0;
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    clk_shadow_regs i_clk_shadow_regs (
        .clk       (clk),
        .rst       (rst),
        .tick_1hz  (tick_1hz),
        .bus_cs    (bus_cs),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    // offsets (R1)
    localparam logic [3:0] A_FLG = 4'h0, A_SEC = 4'h8, A_MIN = 4'h9, A_HR = 4'hA,
                           A_WD = 4'hB, A_DT = 4'hC, A_MON = 4'hD, A_YR = 4'hE, A_CEN = 4'hF;

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_cs = 1'b0; bus_we = 1'b0;
    endtask

    // driver: issue a read and push the expected byte for the monitor
    task automatic bus_read(input logic [3:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_cs = 1'b0;
    endtask

    task automatic do_tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_1hz = 1'b1;
            @(negedge clk); tick_1hz = 1'b0;
        end
    endtask

    task automatic stage_time(input logic [7:0] cen, yr, mon, dt, wd, hr, mi, se);
        bus_write(A_FLG, 8'h02);
        bus_write(A_CEN, cen); bus_write(A_YR, yr); bus_write(A_MON, mon);
        bus_write(A_DT, dt);   bus_write(A_WD, wd); bus_write(A_HR, hr);
        bus_write(A_MIN, mi);  bus_write(A_SEC, se);
        bus_write(A_FLG, 8'h00);
    endtask

    task automatic expect_time(input logic [7:0] cen, yr, mon, dt, wd, hr, mi, se,
                               input string tag);
        bus_read(A_CEN, cen, tag); bus_read(A_YR, yr, tag);  bus_read(A_MON, mon, tag);
        bus_read(A_DT, dt, tag);   bus_read(A_WD, wd, tag);  bus_read(A_HR, hr, tag);
        bus_read(A_MIN, mi, tag);  bus_read(A_SEC, se, tag);
    endtask

    // monitor: read data appears after the edge that sampled the read
    initial begin
        forever begin
            @(posedge clk);
            if (bus_cs && !bus_we) begin
                @(negedge clk);
                if (exp_q.size() > 0) begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    n_cmp++;
                    if (bus_rdata !== e) begin
                        n_bad++;
                        $display("FAIL %s: got %02h expected %02h", t, bus_rdata, e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12 reset state
        n_cmp++;
        if (bus_rdata !== 8'h00) begin
            n_bad++; $display("FAIL R12 rdata after reset: got %02h expected 00", bus_rdata);
        end
        bus_read(A_FLG, 8'h00, "R12 flags");
        expect_time(8'h20, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, "R12 time");

        // R1 reserved offsets
        bus_write(4'h5, 8'hAA);
        bus_read(4'h5, 8'h00, "R1 reserved");
        bus_read(4'h3, 8'h00, "R1 reserved");

        // R3/R5 counting with flags clear
        do_tick(3);
        bus_read(A_SEC, 8'h03, "R5 follow tick");

        // R2 rdata holds between reads
        repeat (3) @(negedge clk);
        n_cmp++;
        if (bus_rdata !== 8'h03) begin
            n_bad++; $display("FAIL R2 hold: got %02h expected 03", bus_rdata);
        end

        // R10 write ignored while stage clear
        bus_write(A_SEC, 8'h45);
        bus_read(A_SEC, 8'h03, "R10 no stage");

        // R6 hold freezes view, counter runs
        bus_write(A_FLG, 8'h01);
        bus_read(A_FLG, 8'h01, "R6 flags");
        do_tick(5);
        bus_read(A_SEC, 8'h03, "R6 frozen");
        bus_write(A_SEC, 8'h30);
        bus_read(A_SEC, 8'h03, "R10 hold only");

        // R7 release, refresh at next tick
        bus_write(A_FLG, 8'h00);
        bus_read(A_SEC, 8'h03, "R7 before tick");
        do_tick(1);
        bus_read(A_SEC, 8'h09, "R7 after tick");

        // R8/R11 staging and masks
        bus_write(A_FLG, 8'hFF);
        bus_read(A_FLG, 8'h03, "R11 flags mask");
        bus_write(A_SEC, 8'hD9);
        bus_read(A_SEC, 8'h59, "R11 sec mask");
        bus_write(A_HR, 8'hE3);
        bus_read(A_HR, 8'h23, "R11 hr mask");
        bus_write(A_WD, 8'hFF);
        bus_read(A_WD, 8'h07, "R11 wday mask");
        do_tick(2);
        bus_read(A_SEC, 8'h59, "R8 frozen in stage");

        // R9/R4 commit and leap day in year 24
        bus_write(A_FLG, 8'h02);
        bus_write(A_CEN, 8'h20); bus_write(A_YR, 8'h24); bus_write(A_MON, 8'h02);
        bus_write(A_DT, 8'h28);  bus_write(A_WD, 8'h07); bus_write(A_HR, 8'h23);
        bus_write(A_MIN, 8'h59); bus_write(A_SEC, 8'h58);
        do_tick(2);
        expect_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h58, "R8 staged");
        bus_write(A_FLG, 8'h00);
        bus_read(A_SEC, 8'h58, "R9 after commit");
        do_tick(1);
        bus_read(A_SEC, 8'h59, "R9 counts from load");
        do_tick(1);
        expect_time(8'h20, 8'h24, 8'h02, 8'h29, 8'h01, 8'h00, 8'h00, 8'h00, "R4 leap 24");

        // R4 non-leap year
        stage_time(8'h20, 8'h23, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
        do_tick(1);
        expect_time(8'h20, 8'h23, 8'h03, 8'h01, 8'h04, 8'h00, 8'h00, 8'h00, "R4 plain 23");

        // R4 year 00, century multiple of 4
        stage_time(8'h20, 8'h00, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
        do_tick(1);
        expect_time(8'h20, 8'h00, 8'h02, 8'h29, 8'h03, 8'h00, 8'h00, 8'h00, "R4 leap 2000");

        // R4 year 00, century not multiple of 4
        stage_time(8'h21, 8'h00, 8'h02, 8'h28, 8'h05, 8'h23, 8'h59, 8'h59);
        do_tick(1);
        expect_time(8'h21, 8'h00, 8'h03, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00, "R4 plain 2100");

        // R4 30-day month
        stage_time(8'h20, 8'h24, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
        do_tick(1);
        expect_time(8'h20, 8'h24, 8'h05, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00, "R4 april");

        // R3 full rollover into next century
        stage_time(8'h20, 8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59);
        do_tick(1);
        expect_time(8'h21, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, "R3 century");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule